// File: doc/BRIEF.md
# Transmit Descriptor Fetcher

This block walks a ring of transmit descriptors kept in host memory. The ring is described by an 18-bit base address, an entry size in 16-bit words, and a count of entries. Each poll request makes the block locate the current entry and read its four leading words over a word-wide request/acknowledge memory port. It then decides what to do with the entry.

A valid, owned entry is handed to the transmitter as a buffer address and a byte length. An entry whose length is out of range is written back with a buffer-length error and skipped. A malformed entry, or a memory timeout, is recorded in an accumulating status word instead.

While a hand-off is outstanding, polls are answered without touching memory. When the transmitter reports completion, the block clears the status bits of the entry, writes it back, and steps to the next entry. Each outcome is reported to the surrounding port logic as a one-cycle pulse on one or more of three event lines: done, transmit, and status-error.

Top module: `txr_fetch`

## Requirements
- R1: After reset, `mem_req`, `tx_valid`, `tx_busy` and all three event pulses are low, `status` is 0x0000, and the ring index is 0.
- R2: The entry address is `ring_base + index * entry_words * 2`, kept to 18 bits. Its four words are read in order at byte offsets +0, +2, +4 and +6. A request stays asserted with a stable address until `mem_ack` or `mem_tmo`.
- R3: Each step of the index goes to index+1, or to 0 when index+1 is not below `ring_len`. A `restart` pulse sets the index to 0.
- R4: If word 2 has any bit set in 7:2, the block writes nothing and pulses `evt_seri` alone. The transmit-ring bit (bit 8) is added to the status, and the index is unchanged.
- R5: If word 2 bit 15 (owner) is clear, the block pulses only `evt_done`. There is no hand-off and no write, and the index is unchanged.
- R6: If word 0 (length) is above 1514 or below 14, the block writes word 2 back at +4. The written value has bit 14 set and bits 15, 13, 12, 11 and 10 cleared. It then writes 0x8000 at +6, pulses `evt_done` with `evt_txi`, and steps the index.
- R7: For an owned, well-formed entry of legal length, the block pulses `tx_valid` with `tx_len` = word 0 and `tx_addr` = word 1 + (word 2 bits 1:0 << 16). In the same cycle it pulses `evt_done` and raises `tx_busy`.
- R8: While `tx_busy` is high, a poll pulses only `evt_done` and issues no memory read.
- R9: On `tx_done` while busy, the block writes word 2 back at +4 with bits 15, 14, 12, 11 and 10 cleared. It then writes 0x0000 at +6, pulses `evt_txi`, drops `tx_busy` and steps the index.
- R10: A `mem_tmo` during a descriptor read stops the fetch. Timeout bit 11 is added to the status and `evt_seri` pulses.
- R11: Every status addition also sets bit 15. If bit 15 was already set, bit 14 is set as well. `stat_clr` clears bits 15:8.
- R12: When a poll and `tx_done` arrive in the same cycle while busy, the poll is answered first with a done-only pulse, and the completion write-back follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 18 | Byte address of ring entry 0 |
| entry_words | input | 8 | Entry size in 16-bit words |
| ring_len | input | 16 | Number of ring entries |
| poll | input | 1 | Poll request pulse |
| restart | input | 1 | Return the index to entry 0 |
| tx_done | input | 1 | Transmitter finished the handed-off entry |
| stat_clr | input | 1 | Clear status bits 15:8 |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 18 | Memory byte address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Request finished |
| mem_tmo | input | 1 | Request timed out |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| tx_valid | output | 1 | Hand-off pulse |
| tx_addr | output | 18 | Buffer byte address |
| tx_len | output | 16 | Buffer byte length |
| tx_busy | output | 1 | A hand-off is outstanding |
| evt_done | output | 1 | Done event pulse |
| evt_txi | output | 1 | Transmit event pulse |
| evt_seri | output | 1 | Status-error event pulse |
| status | output | 16 | Accumulated status word |

## Verification
A new poll and the transmitter's completion can land in the same cycle while an entry is handed off. The bench provokes this by driving `poll` and `tx_done` high on one clock edge. The scoreboard queue then expects a done-only pulse first, followed by the two write-backs and the transmit pulse, with no descriptor read in between. A following poll must fetch the next entry, which confirms that the completion was not lost behind the poll.

// File: rtl/txr_pkg.sv
package txr_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_CHK, ST_WR} seq_st_t;
  typedef enum logic {WB_LENERR, WB_CMPL} wb_kind_t;

  localparam logic [15:0] STAT_TMOT   = 16'h0800;
  localparam logic [15:0] STAT_TRNG   = 16'h0100;
  localparam logic [15:0] STAT_KEEP   = 16'h0B00;
  localparam logic [15:0] W3_BUFL     = 16'h8000;
  localparam logic [15:0] RING_ERR_MS = 16'h00FC;
  localparam logic [15:0] CMPL_CLR    = 16'hDC00;
  localparam logic [15:0] LENERR_CLR  = 16'hBC00;
  localparam logic [15:0] LENERR_SET  = 16'h4000;

  // fold new error bits into the status word with summary and repeat flags
  function automatic logic [15:0] stat_merge(input logic [15:0] old_s,
                                             input logic [15:0] bits);
    logic [15:0] r;
    r = old_s | (bits & STAT_KEEP) | 16'h8000;
    if (old_s[15]) r = r | 16'h4000;
    return r;
  endfunction

  function automatic logic w2_ring_err(input logic [15:0] w2);
    return (w2 & RING_ERR_MS) != 16'h0000;
  endfunction

  function automatic logic [15:0] w2_lenerr(input logic [15:0] w2);
    return (w2 | LENERR_SET) & ~LENERR_CLR;
  endfunction

  function automatic logic [15:0] w2_cmpl(input logic [15:0] w2);
    return w2 & ~CMPL_CLR;
  endfunction

endpackage

// File: rtl/txr_index.sv
module txr_index #(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [IDX_W-1:0] ring_len,
  output logic [IDX_W-1:0] idx
);
  localparam int EXT_W = IDX_W + 1;

  logic [EXT_W-1:0] inc;
  logic             wrap;

  assign inc  = {1'b0, idx} + EXT_W'(1);
  assign wrap = inc >= {1'b0, ring_len};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (clr) begin
      idx <= '0;
    end else if (adv) begin
      idx <= wrap ? '0 : inc[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/txr_status.sv
module txr_status
  import txr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_v,
  input  logic [15:0] set_bits,
  input  logic        clr_hi,
  output logic [15:0] status
);
  logic [15:0] base_s;

  assign base_s = clr_hi ? {8'h00, status[7:0]} : status;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= 16'h0000;
    end else if (set_v) begin
      status <= stat_merge(base_s, set_bits);
    end else begin
      status <= base_s;
    end
  end
endmodule

// File: rtl/txr_seq.sv
module txr_seq
  import txr_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int IDX_W   = 16,
  parameter int ELEN_W  = 8,
  parameter int MIN_LEN = 14,
  parameter int MAX_LEN = 1514
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [ELEN_W-1:0] entry_words,
  input  logic [IDX_W-1:0]  idx,
  input  logic              poll,
  input  logic              tx_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_tmo,
  input  logic [15:0]       mem_rdata,
  output logic              tx_valid,
  output logic [ADDR_W-1:0] tx_addr,
  output logic [15:0]       tx_len,
  output logic              tx_busy,
  output logic              evt_done,
  output logic              evt_txi,
  output logic              evt_seri,
  output logic              stat_v,
  output logic [15:0]       stat_bits,
  output logic              idx_adv,
  output logic [ADDR_W-1:0] ent_addr
);
  localparam int PROD_RAW = IDX_W + ELEN_W + 1;
  localparam int PROD_W   = (PROD_RAW > ADDR_W) ? PROD_RAW : ADDR_W;
  localparam logic [15:0] MIN_L = 16'(MIN_LEN);
  localparam logic [15:0] MAX_L = 16'(MAX_LEN);

  function automatic logic [ADDR_W-1:0] entry_addr(input logic [ADDR_W-1:0] b,
                                                   input logic [IDX_W-1:0]  i,
                                                   input logic [ELEN_W-1:0] e);
    logic [PROD_W-1:0] off;
    off = PROD_W'(i) * PROD_W'(e);
    off = off << 1;
    return b + off[ADDR_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] buf_addr(input logic [15:0] w1,
                                                 input logic [15:0] w2);
    logic [31:0] t;
    t = {14'b0, w2[1:0], w1};
    return t[ADDR_W-1:0];
  endfunction

  function automatic logic len_bad(input logic [15:0] l);
    return (l > MAX_L) || (l < MIN_L);
  endfunction

  seq_st_t     st;
  wb_kind_t    wb;
  logic [1:0]  wcnt;
  logic [15:0] words [4];
  logic        poll_pend;
  logic        done_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      wb        <= WB_LENERR;
      wcnt      <= 2'd0;
      for (int k = 0; k < 4; k++) words[k] <= 16'h0000;
      poll_pend <= 1'b0;
      done_pend <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= 16'h0000;
      tx_valid  <= 1'b0;
      tx_addr   <= '0;
      tx_len    <= 16'h0000;
      tx_busy   <= 1'b0;
      evt_done  <= 1'b0;
      evt_txi   <= 1'b0;
      evt_seri  <= 1'b0;
      stat_v    <= 1'b0;
      stat_bits <= 16'h0000;
      idx_adv   <= 1'b0;
      ent_addr  <= '0;
    end else begin
      tx_valid <= 1'b0;
      evt_done <= 1'b0;
      evt_txi  <= 1'b0;
      evt_seri <= 1'b0;
      stat_v   <= 1'b0;
      idx_adv  <= 1'b0;
      if (poll)    poll_pend <= 1'b1;
      if (tx_done) done_pend <= 1'b1;

      case (st)
        ST_IDLE: begin
          if (poll_pend) begin
            poll_pend <= poll;
            if (tx_busy) begin
              evt_done <= 1'b1;
            end else begin
              ent_addr <= entry_addr(ring_base, idx, entry_words);
              mem_addr <= entry_addr(ring_base, idx, entry_words);
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              wcnt     <= 2'd0;
              st       <= ST_RD;
            end
          end else if (done_pend && tx_busy) begin
            done_pend <= tx_done;
            words[2]  <= w2_cmpl(words[2]);
            words[3]  <= 16'h0000;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= ent_addr + ADDR_W'(4);
            mem_wdata <= w2_cmpl(words[2]);
            wcnt      <= 2'd2;
            wb        <= WB_CMPL;
            idx_adv   <= 1'b1;
            st        <= ST_WR;
          end else if (done_pend) begin
            done_pend <= tx_done;
          end
        end

        ST_RD: begin
          if (mem_tmo) begin
            mem_req   <= 1'b0;
            stat_v    <= 1'b1;
            stat_bits <= STAT_TMOT;
            evt_seri  <= 1'b1;
            st        <= ST_IDLE;
          end else if (mem_ack) begin
            words[wcnt] <= mem_rdata;
            if (wcnt == 2'd3) begin
              mem_req <= 1'b0;
              st      <= ST_CHK;
            end else begin
              wcnt     <= wcnt + 2'd1;
              mem_addr <= ent_addr + ADDR_W'({wcnt + 2'd1, 1'b0});
            end
          end
        end

        ST_CHK: begin
          st <= ST_IDLE;
          if (w2_ring_err(words[2])) begin
            stat_v    <= 1'b1;
            stat_bits <= STAT_TRNG;
            evt_seri  <= 1'b1;
          end else if (!words[2][15]) begin
            evt_done <= 1'b1;
          end else if (len_bad(words[0])) begin
            words[2]  <= w2_lenerr(words[2]);
            words[3]  <= W3_BUFL;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= ent_addr + ADDR_W'(4);
            mem_wdata <= w2_lenerr(words[2]);
            wcnt      <= 2'd2;
            wb        <= WB_LENERR;
            idx_adv   <= 1'b1;
            st        <= ST_WR;
          end else begin
            tx_valid <= 1'b1;
            tx_addr  <= buf_addr(words[1], words[2]);
            tx_len   <= words[0];
            tx_busy  <= 1'b1;
            evt_done <= 1'b1;
          end
        end

        ST_WR: begin
          if (mem_tmo) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            stat_v    <= 1'b1;
            stat_bits <= STAT_TMOT;
            st        <= ST_IDLE;
            if (wb == WB_LENERR) begin
              evt_seri <= 1'b1;
            end else begin
              evt_txi <= 1'b1;
              tx_busy <= 1'b0;
            end
          end else if (mem_ack) begin
            if (wcnt == 2'd2) begin
              wcnt      <= 2'd3;
              mem_addr  <= ent_addr + ADDR_W'(6);
              mem_wdata <= words[3];
            end else begin
              mem_req <= 1'b0;
              mem_we  <= 1'b0;
              st      <= ST_IDLE;
              evt_txi <= 1'b1;
              if (wb == WB_LENERR) begin
                evt_done <= 1'b1;
              end else begin
                tx_busy <= 1'b0;
              end
            end
          end
        end

        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txr_fetch.sv
module txr_fetch
  import txr_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int IDX_W   = 16,
  parameter int ELEN_W  = 8,
  parameter int MIN_LEN = 14,
  parameter int MAX_LEN = 1514
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [ELEN_W-1:0] entry_words,
  input  logic [IDX_W-1:0]  ring_len,
  input  logic              poll,
  input  logic              restart,
  input  logic              tx_done,
  input  logic              stat_clr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_tmo,
  input  logic [15:0]       mem_rdata,
  output logic              tx_valid,
  output logic [ADDR_W-1:0] tx_addr,
  output logic [15:0]       tx_len,
  output logic              tx_busy,
  output logic              evt_done,
  output logic              evt_txi,
  output logic              evt_seri,
  output logic [15:0]       status
);
  logic [IDX_W-1:0]  idx;
  logic              idx_adv;
  logic              stat_v;
  logic [15:0]       stat_bits;
  logic [ADDR_W-1:0] ent_addr;

  txr_index #(.IDX_W(IDX_W)) u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (restart),
    .adv      (idx_adv),
    .ring_len (ring_len),
    .idx      (idx)
  );

  txr_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_v    (stat_v),
    .set_bits (stat_bits),
    .clr_hi   (stat_clr),
    .status   (status)
  );

  txr_seq #(
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .ELEN_W  (ELEN_W),
    .MIN_LEN (MIN_LEN),
    .MAX_LEN (MAX_LEN)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ring_base   (ring_base),
    .entry_words (entry_words),
    .idx         (idx),
    .poll        (poll),
    .tx_done     (tx_done),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .mem_tmo     (mem_tmo),
    .mem_rdata   (mem_rdata),
    .tx_valid    (tx_valid),
    .tx_addr     (tx_addr),
    .tx_len      (tx_len),
    .tx_busy     (tx_busy),
    .evt_done    (evt_done),
    .evt_txi     (evt_txi),
    .evt_seri    (evt_seri),
    .stat_v      (stat_v),
    .stat_bits   (stat_bits),
    .idx_adv     (idx_adv),
    .ent_addr    (ent_addr)
  );
endmodule

// File: rtl/txr_fetch_chk.sv
module txr_fetch_chk #(
  parameter int ADDR_W = 18,
  parameter int IDX_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              mem_tmo,
  input logic              tx_valid,
  input logic              tx_busy,
  input logic              evt_done,
  input logic              evt_txi,
  input logic              evt_seri,
  input logic [15:0]       status,
  input logic [IDX_W-1:0]  idx,
  input logic              idx_adv,
  input logic [IDX_W-1:0]  ring_len,
  input logic [ADDR_W-1:0] ent_addr
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_tmo) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R6
  wr_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ((mem_addr == ent_addr + ADDR_W'(4)) || (mem_addr == ent_addr + ADDR_W'(6))));

  // R7
  handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (evt_done && $rose(tx_busy)));

  // R8
  busy_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req) && $past(tx_busy)) |-> mem_we);

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_adv && (({1'b0, idx} + (IDX_W+1)'(1)) >= {1'b0, ring_len})) |=> (idx == '0));

  // R11
  multi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[14]) |-> $past(status[15]));

  // R10
  seri_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_seri |=> status[15]);

  // R4
  seri_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_seri |-> !(evt_done || evt_txi));
endmodule

bind txr_fetch txr_fetch_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_ack  (mem_ack),
  .mem_tmo  (mem_tmo),
  .tx_valid (tx_valid),
  .tx_busy  (tx_busy),
  .evt_done (evt_done),
  .evt_txi  (evt_txi),
  .evt_seri (evt_seri),
  .status   (status),
  .idx      (idx),
  .idx_adv  (idx_adv),
  .ring_len (ring_len),
  .ent_addr (ent_addr)
);

// File: tb/sim_txr_fetch.sv
module sim_txr_fetch;
  localparam int AW = 18;
  localparam int IW = 16;
  localparam int EW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ring_base = 18'h10000;
  logic [EW-1:0] entry_words = 8'd6;
  logic [IW-1:0] ring_len = 16'd3;
  logic          poll = 1'b0, restart = 1'b0, tx_done = 1'b0, stat_clr = 1'b0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata;
  logic          mem_ack = 1'b0, mem_tmo = 1'b0;
  logic [15:0]   mem_rdata = 16'h0000;
  logic          tx_valid, tx_busy, evt_done, evt_txi, evt_seri;
  logic [AW-1:0] tx_addr;
  logic [15:0]   tx_len, status;

  always #10 clk = ~clk;

  txr_fetch u0 (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .entry_words(entry_words),
    .ring_len(ring_len), .poll(poll), .restart(restart), .tx_done(tx_done),
    .stat_clr(stat_clr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_tmo(mem_tmo), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_addr(tx_addr), .tx_len(tx_len), .tx_busy(tx_busy),
    .evt_done(evt_done), .evt_txi(evt_txi), .evt_seri(evt_seri), .status(status)
  );

  // kinds: 0 write, 1 hand-off, 2 event {seri,txi,done}, 3 read
  typedef struct {
    int            kind;
    logic [AW-1:0] a;
    logic [15:0]   d;
    string         tag;
  } item_t;

  item_t         q[$];
  logic [15:0]   mem [logic [AW-1:0]];
  int            n_run = 0, n_fail = 0;
  logic          tmo_en = 1'b0;
  logic [AW-1:0] tmo_addr = '0;
  int            exp_idx = 0;
  logic          exp_busy = 1'b0;
  logic [15:0]   exp_stat = 16'h0000;
  logic [AW-1:0] cur_ea = '0;
  logic [15:0]   cur_w2 = 16'h0000;
  string         read_tag = "R2";

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [35:0] act, input logic [35:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic got(input int kind, input logic [AW-1:0] a, input logic [15:0] d);
    item_t it;
    if (q.size() == 0) begin
      chk(1'b0, "unexpected", $sformatf("kind%0d", kind), {2'b0, a, d}, 36'h0);
    end else begin
      it = q.pop_front();
      chk(it.kind == kind && it.a == a && it.d == d, it.tag,
          $sformatf("kind%0d/exp%0d", kind, it.kind), {2'b0, a, d}, {2'b0, it.a, it.d});
    end
  endtask

  function automatic logic [15:0] rd(input logic [AW-1:0] a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  function automatic logic [AW-1:0] ea_of(input int i);
    int unsigned s;
    s = int'(ring_base) + i * int'(entry_words) * 2;
    return s[AW-1:0];
  endfunction

  function automatic logic [15:0] smerge(input logic [15:0] s, input logic [15:0] b);
    logic [15:0] n;
    n = s | b | 16'h8000;
    if (s[15]) n = n | 16'h4000;
    return n;
  endfunction

  function automatic int nxt(input int i);
    return (i + 1 >= int'(ring_len)) ? 0 : i + 1;
  endfunction

  task automatic push(input int kind, input logic [AW-1:0] a, input logic [15:0] d,
                      input string tag);
    item_t it;
    it.kind = kind; it.a = a; it.d = d; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic set_entry(input int i, input logic [15:0] w0, input logic [15:0] w1,
                           input logic [15:0] w2, input logic [15:0] w3);
    logic [AW-1:0] a;
    a = ea_of(i);
    mem[a] = w0; mem[a + 2] = w1; mem[a + 4] = w2; mem[a + 6] = w3;
  endtask

  // monitor and memory responder
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid) got(1, tx_addr, tx_len);
      if (evt_done || evt_txi || evt_seri) got(2, '0, {13'b0, evt_seri, evt_txi, evt_done});
    end
    mem_ack <= 1'b0;
    mem_tmo <= 1'b0;
    if (rst_n && mem_req && !mem_ack && !mem_tmo) begin
      if (tmo_en && mem_addr == tmo_addr) begin
        mem_tmo <= 1'b1;
        tmo_en = 1'b0;
      end else begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          got(0, mem_addr, mem_wdata);
        end else begin
          mem_rdata <= rd(mem_addr);
          got(3, mem_addr, 16'h0000);
        end
      end
    end
  end

  // expectation builder for one poll, from the requirements
  task automatic expect_poll();
    logic [AW-1:0] ea;
    logic [15:0]   w0, w1, w2;
    if (exp_busy) begin
      push(2, '0, 16'h0001, "R8");
      return;
    end
    ea = ea_of(exp_idx);
    for (int k = 0; k < 4; k++) begin
      if (tmo_en && (ea + AW'(2 * k)) == tmo_addr) begin
        push(2, '0, 16'h0004, "R10");
        exp_stat = smerge(exp_stat, 16'h0800);
        return;
      end
      push(3, ea + AW'(2 * k), 16'h0000, read_tag);
    end
    w0 = rd(ea); w1 = rd(ea + 2); w2 = rd(ea + 4);
    if (w2[7:2] != 6'd0) begin
      push(2, '0, 16'h0004, "R4");
      exp_stat = smerge(exp_stat, 16'h0100);
    end else if (!w2[15]) begin
      push(2, '0, 16'h0001, "R5");
    end else if (w0 > 16'd1514 || w0 < 16'd14) begin
      push(0, ea + 4, (w2 | 16'h4000) & 16'h43FF, "R6");
      push(0, ea + 6, 16'h8000, "R6");
      push(2, '0, 16'h0003, "R6");
      exp_idx = nxt(exp_idx);
    end else begin
      push(1, AW'({w2[1:0], w1}), w0, "R7");
      push(2, '0, 16'h0001, "R7");
      exp_busy = 1'b1;
      cur_ea = ea;
      cur_w2 = w2;
    end
  endtask

  task automatic expect_cmpl();
    push(0, cur_ea + 4, cur_w2 & 16'h23FF, "R9");
    push(0, cur_ea + 6, 16'h0000, "R9");
    push(2, '0, 16'h0002, "R9");
    exp_busy = 1'b0;
    exp_idx = nxt(exp_idx);
  endtask

  task automatic pulse_poll();
    @(negedge clk) poll = 1'b1;
    @(negedge clk) poll = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk) tx_done = 1'b1;
    @(negedge clk) tx_done = 1'b0;
  endtask

  task automatic drain(input string tag);
    int t;
    t = 0;
    while (q.size() != 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(q.size() == 0, tag, "pending expectations", 36'(q.size()), 36'd0);
    q.delete();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_poll(input string tag);
    expect_poll();
    pulse_poll();
    drain(tag);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!mem_req && !tx_valid && !tx_busy, "R1", "idle outputs", {33'b0, mem_req, tx_valid, tx_busy}, 36'd0);
    chk(!(evt_done || evt_txi || evt_seri), "R1", "event pulses", {33'b0, evt_seri, evt_txi, evt_done}, 36'd0);
    chk(status == 16'h0000, "R1", "status", 36'(status), 36'h0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7 hand-off from entry 0
    set_entry(0, 16'd100, 16'h2000, 16'hBC03, 16'h1234);
    do_poll("R7");
    chk(tx_busy == 1'b1, "R7", "busy", 36'(tx_busy), 36'd1);
    // R8 poll while busy
    do_poll("R8");
    // R9 completion
    expect_cmpl();
    pulse_done();
    drain("R9");
    chk(tx_busy == 1'b0, "R9", "busy cleared", 36'(tx_busy), 36'd0);

    // R6 short and long lengths, the second one wraps the index (R3)
    set_entry(1, 16'd10, 16'h0000, 16'hBC00, 16'h0000);
    do_poll("R6");
    set_entry(2, 16'd1515, 16'h0000, 16'h8000, 16'h0000);
    do_poll("R6");
    read_tag = "R3";
    do_poll("R5");
    read_tag = "R2";
    do_poll("R5");
    chk(status == 16'h0000, "R5", "status untouched", 36'(status), 36'h0);

    // R4 malformed entry
    mem[ea_of(0) + 4] = 16'h8010;
    do_poll("R4");
    chk(status == exp_stat, "R4", "status", 36'(status), 36'(exp_stat));

    // R10 read timeout on word 2; R11 repeat flag
    tmo_en = 1'b1;
    tmo_addr = ea_of(0) + 4;
    do_poll("R10");
    chk(status == 16'hC900 && status == exp_stat, "R11", "status after repeat", 36'(status), 36'hC900);
    @(negedge clk) stat_clr = 1'b1;
    @(negedge clk) stat_clr = 1'b0;
    exp_stat = exp_stat & 16'h00FF;
    @(negedge clk);
    chk(status == exp_stat, "R11", "status clear", 36'(status), 36'(exp_stat));

    // R7 minimum length, then R12 poll with completion in one cycle
    set_entry(0, 16'd14, 16'h0100, 16'h8000, 16'h0000);
    do_poll("R7");
    push(2, '0, 16'h0001, "R12");
    expect_cmpl();
    @(negedge clk) begin poll = 1'b1; tx_done = 1'b1; end
    @(negedge clk) begin poll = 1'b0; tx_done = 1'b0; end
    drain("R12");

    // R7 maximum length with high address bits
    set_entry(1, 16'd1514, 16'hFFFE, 16'h8002, 16'h0000);
    do_poll("R7");
    expect_cmpl();
    pulse_done();
    drain("R9");

    // R3 restart, R2 address wraps within 18 bits
    @(negedge clk) begin
      restart = 1'b1;
      ring_base = 18'h3FFF8;
      entry_words = 8'd4;
    end
    @(negedge clk) restart = 1'b0;
    exp_idx = 0;
    set_entry(0, 16'd2000, 16'h0000, 16'h8000, 16'h0000);
    do_poll("R3");
    set_entry(1, 16'd60, 16'h0000, 16'h0000, 16'h0000);
    do_poll("R2");
    chk(status == exp_stat, "R11", "final status", 36'(status), 36'(exp_stat));

    finish_run();
  end
endmodule